// File: doc/BRIEF.md
# Parallel State-Element Sequence Matcher

This block finds byte sequences in a symbol stream by running a group of small state elements side by side. Each element holds one 8-bit match value, a successor mask that names other elements, a start flag and a terminal flag. Every accepted symbol goes to all elements at the same time. An element that is active, or that has its start flag set, and whose value equals the symbol is said to match. The successor masks of all matching elements are ORed together to form the active set for the next symbol. A sequence such as "abc" is therefore built as a chain of elements, and many chains share one input stream.

A terminal element that matches produces a report giving its element index and the stream offset of the symbol. When several terminal elements match on the same symbol, their reports leave one at a time in ascending index order, and the input stream is held off until all of them have been taken. An addressed port writes an element's configuration and reads it back. Writes are taken only when the engine is idle between symbols. A reset or a restart pulse empties the active set, the offset counter and any pending reports. Neither one disturbs the stored configuration.

The control has two states. RUN accepts symbols and configuration writes. REPORT presents pending reports and blocks input. Transition RUN→REPORT fires when an accepted symbol hits at least one terminal element. Transition REPORT→RUN fires when the last pending report is taken. A reset or a restart pulse forces RUN from either state.

Top module: `seq_automaton`

## Requirements
- R1: After reset, s_ready is 1 and r_valid is 0. The active set is empty and the next accepted symbol has offset 0. Element configuration written before the reset reads back unchanged afterwards.
- R2: When cfg_wr_en is 1 in RUN with s_valid 0, the element at cfg_addr stores the value, successor mask, start flag and terminal flag. cfg_rd_* shows the stored fields of the element at cfg_addr in the same cycle and returns exactly the last accepted write.
- R3: A configuration write is ignored while reports are pending (REPORT), in a cycle where s_valid is 1, or in a cycle where restart is 1.
- R4: A symbol is accepted on a clock edge where s_valid and s_ready are both 1. Element i matches only if it is active or has its start flag, and its stored value equals the symbol.
- R5: After an accepted symbol, the active set is the OR of the successor masks of all matching elements, where bit j of element i's mask activates element j. An active element that does not match becomes inactive. An idle cycle leaves the active set unchanged.
- R6: An element with its start flag set is treated as active for every symbol, so a chain can begin at any stream position.
- R7: Each matching terminal element produces one report. The report carries the element index on r_index and the 32-bit offset of the matching symbol on r_offset. Offsets count accepted symbols from 0.
- R8: Reports from one symbol leave in ascending element index, one per r_valid/r_ready handshake. r_index and r_offset hold steady while r_valid is 1 and r_ready is 0.
- R9: s_ready is 0 while any report is pending. It returns to 1 in the cycle after the last report is taken.
- R10: A restart pulse empties the active set, the offset counter and all pending reports at the next edge, and keeps the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Stream restart pulse |
| s_valid | input | 1 | Input symbol valid |
| s_ready | output | 1 | Engine can take a symbol |
| s_symbol | input | SYM_W | Input symbol |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | IDX_W | Element addressed for write and read |
| cfg_wr_value | input | SYM_W | Match value to store |
| cfg_wr_succ | input | NUM_ELEM | Successor mask to store |
| cfg_wr_start | input | 1 | Start flag to store |
| cfg_wr_term | input | 1 | Terminal flag to store |
| cfg_rd_value | output | SYM_W | Stored match value at cfg_addr |
| cfg_rd_succ | output | NUM_ELEM | Stored successor mask at cfg_addr |
| cfg_rd_start | output | 1 | Stored start flag at cfg_addr |
| cfg_rd_term | output | 1 | Stored terminal flag at cfg_addr |
| r_valid | output | 1 | Report available |
| r_ready | input | 1 | Report consumer ready |
| r_index | output | IDX_W | Index of the reporting element |
| r_offset | output | OFF_W | Stream offset of the matched symbol |

## Verification
The bench targets these corner cases:

- A chain broken by a foreign symbol ("a x b c"). A design that keeps unmatched elements active would report the full chain here.
- Two terminal hits on one symbol with a stalling consumer. A design that reorders the hits, drops one, or lets the index drift during a stall would fail here.
- Configuration writes that land while reports are pending, or in the same cycle as a symbol. A design that takes these writes would show the changed value on readback.
- A restart after a chain prefix, and a restart with reports still queued. These catch designs that leak stale activations, leave a report behind, or keep counting offsets across the restart.

// File: rtl/seq_auto_pkg.sv
package seq_auto_pkg;

    // Control states of the matcher.
    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,  // accepting symbols and configuration writes
        ST_REPORT = 1'b1   // draining pending reports, input held off
    } run_state_e;

endpackage

// File: rtl/sa_elem_array.sv
// Configuration storage and parallel match evaluation for all elements.
module sa_elem_array #(
    parameter  int NUM_ELEM = 16,
    parameter  int SYM_W    = 8,
    localparam int IDX_W    = $clog2(NUM_ELEM)
) (
    input  logic                clk,
    input  logic                wr_go,
    input  logic [IDX_W-1:0]    addr,
    input  logic [SYM_W-1:0]    wr_value,
    input  logic [NUM_ELEM-1:0] wr_succ,
    input  logic                wr_start,
    input  logic                wr_term,
    output logic [SYM_W-1:0]    rd_value,
    output logic [NUM_ELEM-1:0] rd_succ,
    output logic                rd_start,
    output logic                rd_term,
    input  logic [SYM_W-1:0]    symbol,
    input  logic [NUM_ELEM-1:0] active,
    output logic [NUM_ELEM-1:0] next_active,
    output logic [NUM_ELEM-1:0] term_hits,
    output logic [NUM_ELEM-1:0] term_flags
);

    logic [SYM_W-1:0]    val_q  [NUM_ELEM];
    logic [NUM_ELEM-1:0] succ_q [NUM_ELEM];
    logic [NUM_ELEM-1:0] start_q;
    logic [NUM_ELEM-1:0] term_q;
    logic [NUM_ELEM-1:0] match_vec;

    // Configuration is deliberately not reset: it survives reset and restart.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_ELEM; i++) begin
            if (wr_go && addr == IDX_W'(i)) begin
                val_q[i]   <= wr_value;
                succ_q[i]  <= wr_succ;
                start_q[i] <= wr_start;
                term_q[i]  <= wr_term;
            end
        end
    end

    // One comparator per element, all fed the same symbol.
    generate
        for (genvar g = 0; g < NUM_ELEM; g++) begin : g_cmp
            assign match_vec[g] = (active[g] | start_q[g]) && (val_q[g] == symbol);
        end
    endgenerate

    assign term_hits  = match_vec & term_q;
    assign term_flags = term_q;

    // Successor routing: OR of the masks of every matching element.
    always_comb begin
        next_active = '0;
        for (int i = 0; i < NUM_ELEM; i++) begin
            if (match_vec[i]) next_active = next_active | succ_q[i];
        end
    end

    // Combinational readback of the addressed element.
    always_comb begin
        rd_value = '0;
        rd_succ  = '0;
        rd_start = 1'b0;
        rd_term  = 1'b0;
        for (int i = 0; i < NUM_ELEM; i++) begin
            if (addr == IDX_W'(i)) begin
                rd_value = val_q[i];
                rd_succ  = succ_q[i];
                rd_start = start_q[i];
                rd_term  = term_q[i];
            end
        end
    end

endmodule

// File: rtl/sa_lowest_pick.sv
// Picks the lowest set bit of a mask: its index and a one-hot select.
module sa_lowest_pick #(
    parameter  int NUM_ELEM = 16,
    localparam int IDX_W    = $clog2(NUM_ELEM)
) (
    input  logic [NUM_ELEM-1:0] mask,
    output logic [NUM_ELEM-1:0] sel,
    output logic [IDX_W-1:0]    idx
);

    assign sel = mask & (~mask + NUM_ELEM'(1));

    always_comb begin
        idx = '0;
        for (int i = NUM_ELEM - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/seq_automaton.sv
module seq_automaton
    import seq_auto_pkg::*;
#(
    parameter  int NUM_ELEM = 16,
    parameter  int SYM_W    = 8,
    parameter  int OFF_W    = 32,
    localparam int IDX_W    = $clog2(NUM_ELEM)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SYM_W-1:0]    s_symbol,
    input  logic                cfg_wr_en,
    input  logic [IDX_W-1:0]    cfg_addr,
    input  logic [SYM_W-1:0]    cfg_wr_value,
    input  logic [NUM_ELEM-1:0] cfg_wr_succ,
    input  logic                cfg_wr_start,
    input  logic                cfg_wr_term,
    output logic [SYM_W-1:0]    cfg_rd_value,
    output logic [NUM_ELEM-1:0] cfg_rd_succ,
    output logic                cfg_rd_start,
    output logic                cfg_rd_term,
    output logic                r_valid,
    input  logic                r_ready,
    output logic [IDX_W-1:0]    r_index,
    output logic [OFF_W-1:0]    r_offset
);

    run_state_e          state_q, state_d;
    logic [NUM_ELEM-1:0] active_q, pend_q;
    logic [OFF_W-1:0]    offset_q, rep_off_q;
    logic [NUM_ELEM-1:0] next_active, term_hits, term_flags, pick_sel;
    logic [IDX_W-1:0]    pick_idx;
    logic                sym_take, wr_go, last_pop;

    assign sym_take = s_valid && (state_q == ST_RUN) && !restart;
    assign wr_go    = cfg_wr_en && (state_q == ST_RUN) && !s_valid && !restart;
    assign last_pop = (pend_q & ~pick_sel) == '0;

    sa_elem_array #(.NUM_ELEM(NUM_ELEM), .SYM_W(SYM_W)) u_array (
        .clk        (clk),
        .wr_go      (wr_go),
        .addr       (cfg_addr),
        .wr_value   (cfg_wr_value),
        .wr_succ    (cfg_wr_succ),
        .wr_start   (cfg_wr_start),
        .wr_term    (cfg_wr_term),
        .rd_value   (cfg_rd_value),
        .rd_succ    (cfg_rd_succ),
        .rd_start   (cfg_rd_start),
        .rd_term    (cfg_rd_term),
        .symbol     (s_symbol),
        .active     (active_q),
        .next_active(next_active),
        .term_hits  (term_hits),
        .term_flags (term_flags)
    );

    sa_lowest_pick #(.NUM_ELEM(NUM_ELEM)) u_pick (
        .mask(pend_q),
        .sel (pick_sel),
        .idx (pick_idx)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (sym_take && (term_hits != '0)) state_d = ST_REPORT;
            ST_REPORT: if (r_ready && last_pop)           state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
        if (restart) state_d = ST_RUN;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Active set, offset counter and pending report mask.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q  <= '0;
            pend_q    <= '0;
            offset_q  <= '0;
            rep_off_q <= '0;
        end else if (restart) begin
            active_q  <= '0;
            pend_q    <= '0;
            offset_q  <= '0;
        end else if (sym_take) begin
            active_q  <= next_active;
            pend_q    <= term_hits;
            rep_off_q <= offset_q;
            offset_q  <= offset_q + OFF_W'(1);
        end else if (state_q == ST_REPORT && r_ready) begin
            pend_q    <= pend_q & ~pick_sel;
        end
    end

    // Outputs.
    always_comb begin
        s_ready  = (state_q == ST_RUN);
        r_valid  = (state_q == ST_REPORT);
        r_index  = pick_idx;
        r_offset = rep_off_q;
    end

    // Assertions.
    a_r8_report_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPORT) |-> (pend_q != '0));

    a_r9_run_has_none_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (pend_q == '0));

    a_r7_reporter_is_terminal: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> term_flags[r_index]);

    a_r7_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        sym_take |=> (offset_q == $past(offset_q) + OFF_W'(1)));

    a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && !r_ready && !restart) |=>
            (r_valid && $stable(r_index) && $stable(r_offset)));

    a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_ready && !restart) |=> (!r_valid || (r_index > $past(r_index))));

    a_r3_cfg_frozen_in_report: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPORT) |=> $stable(term_flags));

    a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (offset_q == '0 && active_q == '0 && !r_valid));

endmodule

// File: tb/sim_seq_automaton.sv
module sim_seq_automaton;
    localparam int N  = 16;
    localparam int SW = 8;
    localparam int OW = 32;
    localparam int IW = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          rst_n = 1'b0, restart = 1'b0;
    logic          s_valid = 1'b0, s_ready;
    logic [SW-1:0] s_symbol = '0;
    logic          cfg_wr_en = 1'b0;
    logic [IW-1:0] cfg_addr = '0;
    logic [SW-1:0] cfg_wr_value = '0;
    logic [N-1:0]  cfg_wr_succ = '0;
    logic          cfg_wr_start = 1'b0, cfg_wr_term = 1'b0;
    logic [SW-1:0] cfg_rd_value;
    logic [N-1:0]  cfg_rd_succ;
    logic          cfg_rd_start, cfg_rd_term;
    logic          r_valid, r_ready = 1'b1;
    logic [IW-1:0] r_index;
    logic [OW-1:0] r_offset;

    seq_automaton #(.NUM_ELEM(N), .SYM_W(SW), .OFF_W(OW)) u0 (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .s_valid(s_valid), .s_ready(s_ready), .s_symbol(s_symbol),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wr_value(cfg_wr_value),
        .cfg_wr_succ(cfg_wr_succ), .cfg_wr_start(cfg_wr_start), .cfg_wr_term(cfg_wr_term),
        .cfg_rd_value(cfg_rd_value), .cfg_rd_succ(cfg_rd_succ),
        .cfg_rd_start(cfg_rd_start), .cfg_rd_term(cfg_rd_term),
        .r_valid(r_valid), .r_ready(r_ready), .r_index(r_index), .r_offset(r_offset)
    );

    int compared = 0, mismatched = 0;
    bit done = 0, check_en = 0, stall_mode = 0, rr_level = 1;
    int cyc = 0;

    task automatic chk(input longint act, input longint exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model.
    logic [SW-1:0] mval [N];
    logic [N-1:0]  msucc [N];
    bit            mst [N], mtm [N], mwr [N];
    logic [N-1:0]  mact = '0;
    logic [N-1:0]  mnxt;
    int moff = 0, poff = 0;
    int pq[$];
    int log_idx[$], log_off[$];

    always @(posedge clk) begin
        if (!rst_n || restart) begin
            mact = '0; moff = 0; pq.delete();
        end else if (pq.size() > 0) begin
            if (r_ready) void'(pq.pop_front());
        end else if (s_valid) begin
            mnxt = '0;
            for (int i = 0; i < N; i++) begin
                if ((mact[i] || mst[i]) && mval[i] == s_symbol) begin
                    mnxt = mnxt | msucc[i];
                    if (mtm[i]) pq.push_back(i);
                end
            end
            poff = moff; mact = mnxt; moff++;
        end else if (cfg_wr_en) begin
            mval[cfg_addr] = cfg_wr_value; msucc[cfg_addr] = cfg_wr_succ;
            mst[cfg_addr] = cfg_wr_start; mtm[cfg_addr] = cfg_wr_term;
            mwr[cfg_addr] = 1;
        end
    end

    // Consumer ready pattern.
    always @(posedge clk) begin
        #1;
        cyc++;
        r_ready = stall_mode ? ((cyc % 3) != 0) : rr_level;
    end

    // Per-cycle comparison against the model, plus report log.
    always @(negedge clk) begin
        if (check_en && rst_n) begin
            chk(s_ready, pq.size() == 0, "R9 s_ready");
            chk(r_valid, pq.size() != 0, "R7 r_valid");
            if (pq.size() != 0) begin
                chk(r_index, pq[0], "R8 r_index");
                chk(r_offset, poff, "R7 r_offset");
            end
            if (mwr[cfg_addr]) begin
                chk(cfg_rd_value, mval[cfg_addr], "R2 rd_value");
                chk(cfg_rd_succ, msucc[cfg_addr], "R2 rd_succ");
                chk(cfg_rd_start, mst[cfg_addr], "R2 rd_start");
                chk(cfg_rd_term, mtm[cfg_addr], "R2 rd_term");
            end
            if (r_valid && r_ready && !restart) begin
                log_idx.push_back(int'(r_index));
                log_off.push_back(int'(r_offset));
            end
        end
    end

    task automatic cfg_write(input int a, input logic [7:0] v, input logic [N-1:0] sc,
                             input bit st, input bit tm);
        @(posedge clk); #1;
        cfg_wr_en = 1; cfg_addr = IW'(a); cfg_wr_value = v;
        cfg_wr_succ = sc; cfg_wr_start = st; cfg_wr_term = tm;
        @(posedge clk); #1;
        cfg_wr_en = 0;
    endtask

    task automatic send(input logic [7:0] sym);
        bit ok;
        @(posedge clk); #1;
        s_valid = 1; s_symbol = sym;
        do begin
            @(negedge clk); ok = s_ready;
            @(posedge clk);
        end while (!ok);
        #1 s_valid = 0;
    endtask

    task automatic drain();
        do @(negedge clk); while (!(s_ready && !r_valid));
    endtask

    task automatic pulse_restart();
        @(posedge clk); #1 restart = 1;
        @(posedge clk); #1 restart = 0;
    endtask

    task automatic exp_rep(input int k, input int idx, input int off, input string tag);
        chk(log_idx.size() > k ? log_idx[k] : -1, idx, tag);
        chk(log_off.size() > k ? log_off[k] : -1, off, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check_en = 1;
        chk(s_ready, 1, "R1 s_ready after reset");
        chk(r_valid, 0, "R1 r_valid after reset");

        // Configuration: "abc" on 0-2, "ab" on 3-4, "x+y" on 5-6, "c" on 7.
        for (int i = 0; i < N; i++) cfg_write(i, 8'hFF, '0, 0, 0);
        cfg_write(0, "a", N'(16'h0002), 1, 0);
        cfg_write(1, "b", N'(16'h0004), 0, 0);
        cfg_write(2, "c", '0, 0, 1);
        cfg_write(3, "a", N'(16'h0010), 1, 0);
        cfg_write(4, "b", '0, 0, 1);
        cfg_write(5, "x", N'(16'h0060), 1, 0);
        cfg_write(6, "y", '0, 0, 1);
        cfg_write(7, "c", '0, 1, 1);
        cfg_addr = 0;
        @(negedge clk);
        chk(cfg_rd_value, "a", "R2 readback value");
        chk(cfg_rd_succ, 16'h0002, "R2 readback succ");
        chk(cfg_rd_start, 1, "R2 readback start");
        chk(cfg_rd_term, 0, "R2 readback term");

        // Chain and simultaneous terminal hits.
        log_idx.delete(); log_off.delete();
        send("a"); send("b"); send("c"); drain();
        chk(log_idx.size(), 3, "R5 report count for abc");
        exp_rep(0, 4, 1, "R7 first report");
        exp_rep(1, 2, 2, "R5 chain end report");
        exp_rep(2, 7, 2, "R8 ascending second hit");

        // Broken chain: unmatched elements go inactive.
        log_idx.delete(); log_off.delete();
        send("a"); send("x"); send("b"); send("c"); drain();
        chk(log_idx.size(), 1, "R5 broken chain count");
        exp_rep(0, 7, 6, "R4 only single-symbol hit");

        // Start element re-arms on every symbol.
        log_idx.delete(); log_off.delete();
        send("x"); send("x"); send("x"); send("y"); drain();
        chk(log_idx.size(), 1, "R6 loop count");
        exp_rep(0, 6, 10, "R6 loop report");

        // Stalling consumer.
        log_idx.delete(); log_off.delete();
        stall_mode = 1;
        send("a"); send("b"); send("c"); drain();
        stall_mode = 0;
        chk(log_idx.size(), 3, "R8 stalled count");
        exp_rep(0, 4, 12, "R8 stalled first");
        exp_rep(1, 2, 13, "R8 stalled second");
        exp_rep(2, 7, 13, "R8 stalled third");

        // Writes blocked while reports are pending or a symbol is present.
        log_idx.delete(); log_off.delete();
        rr_level = 0;
        send("c");
        cfg_write(7, "q", '1, 1, 0);
        cfg_addr = 7;
        @(negedge clk);
        chk(r_valid, 1, "R9 report still pending");
        chk(cfg_rd_value, "c", "R3 write during report ignored");
        chk(cfg_rd_term, 1, "R3 term kept");
        rr_level = 1;
        drain();
        exp_rep(0, 7, 14, "R7 pending report offset");
        @(posedge clk); #1;
        s_valid = 1; s_symbol = "z";
        cfg_wr_en = 1; cfg_addr = 7; cfg_wr_value = "q"; cfg_wr_succ = '1;
        @(posedge clk); #1;
        s_valid = 0; cfg_wr_en = 0;
        @(negedge clk);
        chk(cfg_rd_value, "c", "R3 write with symbol ignored");

        // Restart clears activations and offset.
        send("a");
        pulse_restart();
        log_idx.delete(); log_off.delete();
        send("b"); send("c"); drain();
        chk(log_idx.size(), 1, "R10 stale activation dropped");
        exp_rep(0, 7, 1, "R10 offset restarted");
        rr_level = 0;
        send("c");
        @(negedge clk);
        chk(r_valid, 1, "R7 report raised");
        pulse_restart();
        @(negedge clk);
        chk(r_valid, 0, "R10 pending cleared");
        chk(s_ready, 1, "R10 input reopened");
        rr_level = 1;

        // Reset keeps configuration.
        @(posedge clk); #1 rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        cfg_addr = 0;
        @(negedge clk);
        chk(s_ready, 1, "R1 s_ready after second reset");
        chk(r_valid, 0, "R1 r_valid after second reset");
        chk(cfg_rd_value, "a", "R1 config kept over reset");
        log_idx.delete(); log_off.delete();
        send("a"); send("b"); drain();
        chk(log_idx.size(), 1, "R1 count after reset");
        exp_rep(0, 4, 1, "R1 offset from zero");

        repeat (4) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R9 watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule